// File: doc/BRIEF.md
# Reloading Timer Channel with Tone and Carrier Output

This block is one 8-bit down-counting channel driven through a power-of-two prescaler from the CPU clock. Software loads a reload value and a clock-select code, then picks one of four behaviours through a two-bit mode field. In timer mode, each expiry produces a single-cycle interrupt pulse. In tone mode, a square wave toggles on every expiry and feeds a sound channel. In carrier mode, the same square wave is spliced into a port pin's output, but only while that port bit matches a software-chosen level. The remaining mode leaves the channel idle.

A single counter and a single square-wave flop serve all three active behaviours. Changing the mode restarts the channel from a clean state. A new reload value written during a count is held until the current period ends. The PWM mixing and volume stages that follow the tone output belong to other blocks.

Top module: `tone_timer_chan`

## Requirements
- R1: After reset, `irq_pulse` and `tone_out` are 0, the channel is idle, and `pin_out` equals `port_bit_in`.
- R2: Clock-select code k (address 0, bits 2:0) gives one prescaled tick every 2^(k+1) CPU clocks, for k from 0 to 7.
- R3: In timer mode with reload N and tick spacing D, interrupt pulses follow each other every (N+1)*D clocks, and each pulse lasts exactly one clock.
- R4: A control write that changes the mode restarts the channel. The first expiry falls (N+1)*D clock edges after the edge that took the write.
- R5: A reload value written while the channel runs does not shorten or extend the period in progress. It is first used at the next reload.
- R6: In tone mode, `tone_out` toggles on every expiry, giving a half period of (N+1)*D clocks.
- R7: `irq_pulse` is raised only in timer mode. Tone and carrier modes never raise it.
- R8: A mode change drives the square wave, and with it `tone_out`, to 0 on the same edge. In idle mode the channel stays silent.
- R9: In carrier mode (mode code 10), `pin_out` carries the square wave while `port_bit_in` equals the polarity bit (control bit 2), and equals `port_bit_in` otherwise. `tone_out` stays 0 in this mode.
- R10: Register map on `wr_addr`: 0 is clock select, 1 is reload, 2 is control (bits 1:0 mode: 00 idle, 01 timer, 10 carrier, 11 tone; bit 2 carrier polarity). A write to address 3 has no effect. Rewriting the current mode does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| port_bit_in | input | 1 | Port data bit that the carrier may be spliced into |
| irq_pulse | output | 1 | One-cycle pulse per expiry in timer mode |
| tone_out | output | 1 | Square wave toward the sound channel |
| pin_out | output | 1 | Port pin value after carrier insertion |

## Verification
A wrong count or prescaler state shows up as an interval between interrupt pulses, tone edges or pin edges that differs from (N+1)*D. The error is visible within one period of the channel. A square-wave flop that is not cleared on a mode change shows up at once, as a stray `tone_out` edge or a wrong `pin_out` level on the edge that takes the write. A mode decode fault shows up as an interrupt pulse or output edge in a mode that must not produce one. The scoreboard times every event against the edge of the mode write, so a one-cycle offset anywhere on the path is reported.

// File: rtl/tt_pkg.sv
package tt_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE    = 2'b00,
      MODE_TIMER   = 2'b01,
      MODE_CARRIER = 2'b10,
      MODE_TONE    = 2'b11
   } tt_mode_e;

   localparam logic [1:0] ADDR_CLKSEL = 2'd0;
   localparam logic [1:0] ADDR_RELOAD = 2'd1;
   localparam logic [1:0] ADDR_CTRL   = 2'd2;

   localparam int CTRL_POL_BIT = 2;

endpackage

// File: rtl/tt_regs.sv
module tt_regs
   import tt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 8,
   parameter int SEL_W       = 3,
   parameter bit HAS_CARRIER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEL_W-1:0]  clk_sel,
   output logic [CNT_W-1:0]  reload,
   output tt_mode_e          mode,
   output logic              carrier_pol,
   output logic              restart
);

   logic     ctrl_wr;
   tt_mode_e wr_mode;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

   // mode decode; the carrier code collapses to idle when the variant lacks it
   always_comb begin
      unique case (wr_data[1:0])
         2'b01:   wr_mode = MODE_TIMER;
         2'b11:   wr_mode = MODE_TONE;
         2'b10:   wr_mode = HAS_CARRIER ? MODE_CARRIER : MODE_IDLE;
         default: wr_mode = MODE_IDLE;
      endcase
   end

   assign restart = ctrl_wr && (wr_mode != mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_sel     <= '0;
         reload      <= '1;
         mode        <= MODE_IDLE;
         carrier_pol <= 1'b0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_CLKSEL: clk_sel <= wr_data[SEL_W-1:0];
            ADDR_RELOAD: reload  <= wr_data[CNT_W-1:0];
            ADDR_CTRL: begin
               mode        <= wr_mode;
               carrier_pol <= wr_data[CTRL_POL_BIT];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int PRE_W = 1 << SEL_W;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   // low (sel+1) bits all ones marks the last clock of a 2^(sel+1) window
   always_comb begin
      for (int i = 0; i < PRE_W; i++) begin
         mask[i] = (i <= int'(sel));
      end
   end

   assign tick = run && ((pre_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/tt_counter.sv
module tt_counter
   import tt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  tt_mode_e         mode,
   input  logic [CNT_W-1:0] reload,
   output logic             irq,
   output logic             sq
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;
   logic             wave_mode;

   assign at_zero   = (cnt_q == '0);
   assign wave_mode = (mode == MODE_TONE) || (mode == MODE_CARRIER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '1;
         sq    <= 1'b0;
         irq   <= 1'b0;
      end else if (restart) begin
         cnt_q <= reload;
         sq    <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (tick) begin
            if (at_zero) begin
               cnt_q <= reload;
               if (mode == MODE_TIMER) irq <= 1'b1;
               if (wave_mode)          sq  <= ~sq;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tt_pin_mux.sv
module tt_pin_mux
   import tt_pkg::*;
#(
   parameter bit HAS_CARRIER = 1'b1
) (
   input  tt_mode_e mode,
   input  logic     carrier_pol,
   input  logic     sq,
   input  logic     port_bit,
   output logic     pin
);

   generate
      if (HAS_CARRIER) begin : g_carrier
         logic gate_on;
         assign gate_on = (mode == MODE_CARRIER) && (port_bit == carrier_pol);
         assign pin     = gate_on ? sq : port_bit;
      end else begin : g_plain
         logic unused_ok;
         assign unused_ok = ^{mode, carrier_pol, sq};
         assign pin       = port_bit;
      end
   endgenerate

endmodule

// File: rtl/tone_timer_chan.sv
module tone_timer_chan
   import tt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 8,
   parameter int SEL_W       = 3,
   parameter bit HAS_CARRIER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              port_bit_in,
   output logic              irq_pulse,
   output logic              tone_out,
   output logic              pin_out
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("tone_timer_chan: CNT_W must lie in 2..DATA_W");
      end
      if (SEL_W < 1 || SEL_W > 4 || SEL_W > DATA_W) begin : g_bad_sel
         $error("tone_timer_chan: SEL_W must lie in 1..4");
      end
      if (DATA_W <= CTRL_POL_BIT) begin : g_bad_data
         $error("tone_timer_chan: DATA_W too narrow for the control fields");
      end
   endgenerate

   logic [SEL_W-1:0] clk_sel;
   logic [CNT_W-1:0] reload;
   tt_mode_e         mode_q;
   logic             carrier_pol;
   logic             restart;
   logic             tick;
   logic             sq_q;
   logic             run;

   tt_regs #(
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .SEL_W       (SEL_W),
      .HAS_CARRIER (HAS_CARRIER)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .clk_sel     (clk_sel),
      .reload      (reload),
      .mode        (mode_q),
      .carrier_pol (carrier_pol),
      .restart     (restart)
   );

   assign run = (mode_q != MODE_IDLE);

   tt_prescaler #(
      .SEL_W (SEL_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .sel     (clk_sel),
      .tick    (tick)
   );

   tt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (restart),
      .mode    (mode_q),
      .reload  (reload),
      .irq     (irq_pulse),
      .sq      (sq_q)
   );

   tt_pin_mux #(
      .HAS_CARRIER (HAS_CARRIER)
   ) u_pin (
      .mode        (mode_q),
      .carrier_pol (carrier_pol),
      .sq          (sq_q),
      .port_bit    (port_bit_in),
      .pin         (pin_out)
   );

   assign tone_out = sq_q && (mode_q == MODE_TONE);

endmodule

// File: rtl/tt_chk.sv
module tt_chk
   import tt_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     irq,
   input logic     sq,
   input logic     restart,
   input logic     tick,
   input tt_mode_e mode,
   input logic     pin,
   input logic     port
);

   // R3: an interrupt pulse never lasts two clocks
   assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R7: interrupts only while in timer mode
   assert_irq_timer_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mode == MODE_TIMER));

   // R8: a mode change leaves the square wave low
   assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sq);

   // R6: the square wave moves only on a prescaled tick
   assert_sq_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(restart) && (sq != $past(sq))) |-> $past(tick));

   // R2: prescaled ticks are at least two clocks apart
   assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R9: outside carrier mode the pin follows the port bit
   assert_pin_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_CARRIER) |-> (pin == port));

endmodule

bind tone_timer_chan tt_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq_pulse),
   .sq      (sq_q),
   .restart (restart),
   .tick    (tick),
   .mode    (mode_q),
   .pin     (pin_out),
   .port    (port_bit_in)
);

// File: tb/tb_tone_timer_chan.sv
`timescale 1ns/1ps
module tb_tone_timer_chan;

   localparam int K_IRQ  = 0;
   localparam int K_TONE = 1;
   localparam int K_PIN  = 2;

   typedef struct {
      int    kind;
      int    gap;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       port_bit_in = 1'b0;
   logic       irq_pulse, tone_out, pin_out;

   int   cyc = 0;
   int   ref_cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   mon_pin = 1'b0;
   bit   done = 1'b0;
   logic irq_prev = 1'b0, tone_prev = 1'b0, pin_prev = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tone_timer_chan dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .port_bit_in (port_bit_in),
      .irq_pulse   (irq_pulse),
      .tone_out    (tone_out),
      .pin_out     (pin_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic set_mode(input logic [7:0] d);
      wr(2'd2, d);
      ref_cyc = cyc;
   endtask

   task automatic push(input int kind, input int gap, input string req);
      exp_t e;
      e.kind = kind; e.gap = gap; e.req = req;
      q.push_back(e);
   endtask

   task automatic drain(input int limit, input string req);
      int n = 0;
      while (q.size() != 0 && n < limit) begin
         @(negedge clk);
         #1;
         n++;
      end
      check(q.size() == 0, req, "expected events still pending", q.size(), 0);
      q.delete();
   endtask

   task automatic handle(input int kind);
      exp_t e;
      string tag;
      int gap;
      gap = cyc - ref_cyc;
      ref_cyc = cyc;
      tag = (kind == K_IRQ) ? "R7" : (kind == K_TONE) ? "R6" : "R9";
      if (q.size() == 0) begin
         check(1'b0, tag, "unexpected output event of kind", kind, -1);
      end else begin
         e = q.pop_front();
         check(e.kind == kind, e.req, "event kind", kind, e.kind);
         check(e.gap == gap, e.req, "event spacing in clocks", gap, e.gap);
      end
   endtask

   // monitor: samples away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (irq_pulse && !irq_prev)   handle(K_IRQ);
         if (tone_out != tone_prev)    handle(K_TONE);
         if (mon_pin && pin_out != pin_prev) handle(K_PIN);
      end
      irq_prev  = irq_pulse;
      tone_prev = tone_out;
      pin_prev  = pin_out;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit pin_ok;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(irq_pulse == 1'b0, "R1", "irq after reset", irq_pulse, 0);
      check(tone_out == 1'b0, "R1", "tone after reset", tone_out, 0);
      check(pin_out == port_bit_in, "R1", "pin passthrough low", pin_out, port_bit_in);
      port_bit_in = 1'b1;
      #1;
      check(pin_out == 1'b1, "R1", "pin passthrough high", pin_out, 1);

      // R3/R4: timer mode, D=2, N=4 -> 10 clocks
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd4);
      set_mode(8'h01);
      push(K_IRQ, 10, "R4");
      push(K_IRQ, 10, "R3");
      push(K_IRQ, 10, "R3");
      drain(200, "R3");
      set_mode(8'h00);

      // R2/R5: D=16, N=2 -> 48; reload 5 written mid-period -> 96 afterwards
      wr(2'd0, 8'd3);
      wr(2'd1, 8'd2);
      set_mode(8'h01);
      push(K_IRQ, 48, "R2");
      push(K_IRQ, 48, "R5");
      push(K_IRQ, 96, "R5");
      repeat (60) @(posedge clk);
      wr(2'd1, 8'd5);
      drain(400, "R5");
      set_mode(8'h00);

      // R10: address 3 ignored, same-mode rewrite does not restart
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd2);
      set_mode(8'h01);
      push(K_IRQ, 6, "R10");
      push(K_IRQ, 6, "R10");
      push(K_IRQ, 6, "R10");
      push(K_IRQ, 6, "R10");
      repeat (2) @(posedge clk);
      wr(2'd3, 8'h00);
      repeat (3) @(posedge clk);
      wr(2'd2, 8'h01);
      drain(200, "R10");
      set_mode(8'h00);

      // R6/R8: tone mode, D=4, N=3 -> half period 16, then leave mode while high
      wr(2'd0, 8'd1);
      wr(2'd1, 8'd3);
      set_mode(8'h03);
      push(K_TONE, 16, "R6");
      push(K_TONE, 16, "R6");
      push(K_TONE, 16, "R6");
      drain(200, "R6");
      check(tone_out == 1'b1, "R6", "tone level after three toggles", tone_out, 1);
      set_mode(8'h00);
      push(K_TONE, 0, "R8");
      drain(20, "R8");
      repeat (30) @(negedge clk);
      check(tone_out == 1'b0, "R8", "tone after leaving mode", tone_out, 0);

      // R9: carrier, polarity 1, port bit 1 -> pin carries the wave (D=2, N=1)
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd1);
      mon_pin = 1'b1;
      set_mode(8'h06);
      push(K_PIN, 0, "R9");
      push(K_PIN, 4, "R9");
      push(K_PIN, 4, "R9");
      push(K_PIN, 4, "R9");
      drain(100, "R9");
      check(tone_out == 1'b0, "R9", "tone in carrier mode", tone_out, 0);
      mon_pin = 1'b0;
      set_mode(8'h00);
      @(negedge clk);
      check(pin_out == 1'b1, "R9", "pin after carrier off", pin_out, 1);

      // R9: carrier, polarity 0, port bit 1 -> gate closed, pin follows port
      mon_pin = 1'b1;
      set_mode(8'h02);
      pin_ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pin_out !== 1'b1) pin_ok = 1'b0;
      end
      check(pin_ok, "R9", "pin held while gate closed", pin_out, 1);
      check(q.size() == 0, "R9", "events while gate closed", q.size(), 0);
      mon_pin = 1'b0;
      set_mode(8'h00);
      repeat (5) @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule